// File: doc/BRIEF.md
# Uncached Store Write Formatter

This block sits between a processor's store port and an uncached memory path. The bus behind it is 64 bits wide. The block takes one store request, made of a byte address, 32 bits of data, a size of one, two or four bytes and a byte-reverse flag. It turns that request into the aligned 32-bit word writes that the memory actually sees.

An aligned full-word store becomes a single write. Every other store behaves in an unusual way. Bytes are not masked. The prepared data is rotated, and the same rotated word is written whole into both halves of each 8-byte unit that the store touches.

Each store accepted on this path also sets a sticky error-interrupt flag. Software clears the flag by writing to a status register. Writes leave the block one at a time under a valid/ready handshake. A new request is taken only after the previous request's last write has been accepted.

Top module: `ucst_fmt`

## Requirements
- R1: A store with address bits [1:0] equal to 0 and size code 2 (word) produces exactly one write, to the request address, carrying the prepared data unrotated.
- R2: Any store with address bits [1:0] nonzero, or with size code 0 or 1, takes the replicating path described in R3 and R4.
- R3: On the replicating path, the prepared data is rotated right by ((addr[1:0] + bytes) mod 4) × 8 bits before it is written. Here bytes is 1, 2 or 4.
- R4: On the replicating path, writes go to addr rounded down to a multiple of 8, then to each following +4 step. There are 2 writes when addr[2:0] + bytes ≤ 8 and 4 writes otherwise. Every write of one request carries the same data word.
- R5: With req_swap = 1, a halfword store exchanges bits [7:0] and [15:8], and a word store reverses all four bytes. A byte store ignores the flag. The reversal is applied before the rotation.
- R6: Size code 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. A byte store uses req_data[7:0] and a halfword store uses req_data[15:0], each zero-extended. The upper input bits have no effect on the output.
- R7: Each write is presented with wr_valid and held unchanged until wr_ready is seen. req_ready stays low from the accepting cycle until the last write has been accepted.
- R8: Each accepted store sets err_irq, which stays set until cleared. A write to the status register with bit 0 = 1 clears it on the next cycle, and bit 0 = 0 leaves it alone. A store accepted in the same cycle as a clear leaves err_irq set.
- R9: After reset, req_ready = 1, wr_valid = 0 and err_irq = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | AW | Store byte address |
| req_data | input | 32 | Store data, right-justified |
| req_size | input | 2 | Size code: 0 byte, 1 halfword, 2/3 word |
| req_swap | input | 1 | Byte-reverse the store data |
| wr_valid | output | 1 | Bus write present |
| wr_ready | input | 1 | Bus accepts the write |
| wr_addr | output | AW | Word-aligned write address |
| wr_data | output | 32 | Write data |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 32 | Status register write data; bit 0 = 1 clears the flag |
| err_irq | output | 1 | Sticky error-interrupt flag |

## Verification
Two events can land on the same clock edge: a store being accepted, which sets the error flag, and a software clear of that flag. The bench raises the status-register clear in the same cycle as a request handshake. It then requires err_irq to read 1 afterwards, and a later clear on its own must bring the flag to 0. A separate scenario stalls wr_ready partway through a four-write burst. This confirms that the held write and the blocked request port do not interact.

// File: rtl/ucst_pkg.sv
package ucst_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int IDX_W   = 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } st_size_e;

    typedef struct packed {
        logic              quirk;
        logic [IDX_W-1:0]  last_idx;
        logic [DATA_W-1:0] data;
    } st_plan_t;

endpackage

// File: rtl/ucst_prep.sv
module ucst_prep
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        size,
    input  logic              swap,
    output st_plan_t          plan,
    output logic [AW-1:0]     base
);

    logic [2:0]          bytes_n;
    logic [DATA_W-1:0]   masked;
    logic [DATA_W-1:0]   rev_word;
    logic [DATA_W-1:0]   shaped;
    logic [1:0]          rot_units;
    logic [4:0]          rot_bits;
    logic [2*DATA_W-1:0] dbl;
    logic [3:0]          span;
    logic                is_word;

    // Full byte reversal of the word, one lane per generate step
    for (genvar g = 0; g < LANES; g++) begin : g_rev
        assign rev_word[8*g +: 8] = data[8*(LANES-1-g) +: 8];
    end

    always_comb begin
        is_word = (size == SZ_WORD) || (size == SZ_RSVD);
        unique case (size)
            SZ_BYTE: bytes_n = 3'd1;
            SZ_HALF: bytes_n = 3'd2;
            default: bytes_n = 3'd4;
        endcase

        // Lane selection and optional reversal, done before any rotation
        masked = '0;
        unique case (size)
            SZ_BYTE: masked[7:0]  = data[7:0];
            SZ_HALF: masked[15:0] = swap ? {data[7:0], data[15:8]} : data[15:0];
            default: masked       = swap ? rev_word : data;
        endcase

        plan.quirk = (addr[1:0] != 2'b00) || !is_word;

        rot_units = addr[1:0] + bytes_n[1:0];
        rot_bits  = {rot_units, 3'b000};
        dbl       = {masked, masked} >> rot_bits;
        shaped    = dbl[DATA_W-1:0];

        span = {1'b0, addr[2:0]} + {1'b0, bytes_n};

        if (plan.quirk) begin
            plan.data     = shaped;
            plan.last_idx = (span > 4'd8) ? 2'd3 : 2'd1;
            base          = {addr[AW-1:3], 3'b000};
        end else begin
            plan.data     = masked;
            plan.last_idx = 2'd0;
            base          = addr;
        end
    end

endmodule

// File: rtl/ucst_seq.sv
module ucst_seq
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  st_plan_t          plan,
    input  logic [AW-1:0]     base,
    output logic              req_ready,
    output logic              req_fire,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [AW-1:0]     wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  last;
        logic [AW-1:0]     base;
        logic [DATA_W-1:0] data;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        req_ready = !st_q.busy;
        req_fire  = req_valid && req_ready;
        if (req_fire) begin
            st_d.busy = 1'b1;
            st_d.idx  = '0;
            st_d.last = plan.last_idx;
            st_d.base = base;
            st_d.data = plan.data;
        end else if (st_q.busy && wr_ready) begin
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_valid = st_q.busy;
    assign wr_addr  = st_q.base + (AW'(st_q.idx) << 2);
    assign wr_data  = st_q.data;

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00)); // R4
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R7
    AST_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!wr_valid || $stable(wr_data))); // R4
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + AW'(4)))); // R4

endmodule

// File: rtl/ucst_irq.sv
module ucst_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    typedef struct packed {
        logic flag;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_evt) begin
            st_d.flag = 1'b1;
        end else if (clr_evt) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag); // R8
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_evt) |=> flag); // R8
    AST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag); // R8

endmodule

// File: rtl/ucst_fmt.sv
module ucst_fmt
    import ucst_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_data,
    input  logic [1:0]    req_size,
    input  logic          req_swap,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [31:0]   wr_data,
    input  logic          stat_we,
    input  logic [31:0]   stat_wdata,
    output logic          err_irq
);

    st_plan_t      plan;
    logic [AW-1:0] base;
    logic          req_fire;
    logic          clr_evt;

    ucst_prep #(.AW(AW)) u_prep (
        .addr (req_addr),
        .data (req_data),
        .size (req_size),
        .swap (req_swap),
        .plan (plan),
        .base (base)
    );

    ucst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .plan      (plan),
        .base      (base),
        .req_ready (req_ready),
        .req_fire  (req_fire),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    assign clr_evt = stat_we && stat_wdata[0];

    ucst_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (req_fire),
        .clr_evt (clr_evt),
        .flag    (err_irq)
    );

    AST_BLOCK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R7

endmodule

// File: tb/ucst_fmt_bench.sv
module ucst_fmt_bench;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic [AW-1:0] req_addr;
    logic [31:0]   req_data;
    logic [1:0]    req_size;
    logic          req_swap;
    logic          wr_valid;
    logic          wr_ready;
    logic [AW-1:0] wr_addr;
    logic [31:0]   wr_data;
    logic          stat_we;
    logic [31:0]   stat_wdata;
    logic          err_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ucst_fmt #(.AW(AW)) u_ucst_fmt (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_data (req_data),
        .req_size (req_size), .req_swap (req_swap),
        .wr_valid (wr_valid), .wr_ready (wr_ready),
        .wr_addr (wr_addr), .wr_data (wr_data),
        .stat_we (stat_we), .stat_wdata (stat_wdata),
        .err_irq (err_irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Independent model of the expected write stream
    task automatic model(input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                         input logic sw, output int n, output logic [31:0] base,
                         output logic [31:0] val);
        int nb;
        logic [31:0] v;
        logic [63:0] dd;
        int rot;
        if (sz == 2'd0) begin
            nb = 1; v = {24'h0, d[7:0]};
        end else if (sz == 2'd1) begin
            nb = 2; v = sw ? {16'h0, d[7:0], d[15:8]} : {16'h0, d[15:0]};
        end else begin
            nb = 4; v = sw ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
        end
        if (a[1:0] == 2'b00 && nb == 4) begin
            n = 1; base = a; val = v;
        end else begin
            rot = ((int'(a[1:0]) + nb) % 4) * 8;
            dd  = {v, v} >> rot;
            val = dd[31:0];
            base = {a[31:3], 3'b000};
            n = ((int'(a[2:0]) + nb) > 8) ? 4 : 2;
        end
    endtask

    task automatic do_store(input string req, input logic [31:0] a, input logic [31:0] d,
                            input logic [1:0] sz, input logic sw, input logic [15:0] rdy_mask,
                            input logic clr_same);
        int n_exp, got;
        logic [31:0] base, val;
        model(a, d, sz, sw, n_exp, base, val);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_size = sz; req_swap = sw;
        if (clr_same) begin
            stat_we = 1'b1; stat_wdata = 32'h1;
        end
        check({req, " R7 ready before request"}, 64'(req_ready), 64'd1);
        got = 0;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            req_valid = 1'b0; stat_we = 1'b0; stat_wdata = '0;
            wr_ready = rdy_mask[k];
            if (wr_valid) check({req, " R7 request blocked"}, 64'(req_ready), 64'd0);
            if (wr_valid && wr_ready) begin
                check({req, " R4 address"}, 64'(wr_addr), 64'(base + 32'(4 * got)));
                check({req, " R3 data"}, 64'(wr_data), 64'(val));
                got++;
            end
        end
        wr_ready = 1'b1;
        check({req, " R4 write count"}, 64'(got), 64'(n_exp));
        check({req, " R8 flag set"}, 64'(err_irq), 64'd1);
    endtask

    task automatic clear_flag(input logic bit0);
        @(negedge clk);
        stat_we = 1'b1; stat_wdata = {31'h7FFF_FFFF, bit0};
        @(negedge clk);
        stat_we = 1'b0; stat_wdata = '0;
    endtask

    task automatic t_reset();
        check("R9 req_ready", 64'(req_ready), 64'd1);
        check("R9 wr_valid", 64'(wr_valid), 64'd0);
        check("R9 err_irq", 64'(err_irq), 64'd0);
    endtask

    task automatic t_plain();
        do_store("R1 aligned word", 32'h100, 32'hA1B2_C3D4, 2'd2, 1'b0, 16'hFFFF, 1'b0);
        do_store("R1 R5 aligned word swapped", 32'h108, 32'h1234_5678, 2'd2, 1'b1, 16'hFFFF, 1'b0);
        do_store("R6 size code 3 as word", 32'h10C, 32'h0BAD_F00D, 2'd3, 1'b0, 16'hFFFF, 1'b0);
    endtask

    task automatic t_bytes();
        for (int o = 0; o < 8; o++)
            do_store("R2 R6 byte store", 32'h200 + 32'(o), 32'hCAFE_BA5E, 2'd0, o[0],
                     16'hFFFF, 1'b0);
    endtask

    task automatic t_halves();
        for (int o = 0; o < 8; o++)
            do_store("R2 R5 halfword store", 32'h300 + 32'(o), 32'h1234_5678, 2'd1, o[1],
                     16'hFFFF, 1'b0);
    endtask

    task automatic t_words();
        for (int o = 1; o < 8; o++)
            do_store("R3 R4 misaligned word", 32'h400 + 32'(o), 32'h1234_5678, 2'd2, o[0],
                     16'hFFFF, 1'b0);
    endtask

    task automatic t_upper_ignored();
        do_store("R6 byte upper bits", 32'h503, 32'hFFFF_FF5A, 2'd0, 1'b0, 16'hFFFF, 1'b0);
        do_store("R6 half upper bits", 32'h506, 32'hEEEE_1234, 2'd1, 1'b0, 16'hFFFF, 1'b0);
    endtask

    task automatic t_stall();
        do_store("R7 stalled burst", 32'h606, 32'h8765_4321, 2'd2, 1'b0, 16'b1101_0110_1010_0100, 1'b0);
    endtask

    task automatic t_irq();
        clear_flag(1'b0);
        check("R8 bit0 zero no effect", 64'(err_irq), 64'd1);
        clear_flag(1'b1);
        check("R8 clear", 64'(err_irq), 64'd0);
        do_store("R8 set wins over clear", 32'h700, 32'h1, 2'd0, 1'b0, 16'hFFFF, 1'b1);
        clear_flag(1'b1);
        check("R8 clear after set", 64'(err_irq), 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_size = '0;
        req_swap = 1'b0; wr_ready = 1'b1; stat_we = 1'b0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_bytes();
        t_halves();
        t_words();
        t_upper_ignored();
        t_stall();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule